// File: doc/BRIEF.md
# SPI CAN-Controller Command Interpreter

This block is the host-side front end of a CAN controller. It is an SPI mode 0 slave (clock idles low, data sampled on the rising edge, changed on the falling edge). It owns a 128-byte register file. Each chip-select frame begins with a one-byte instruction. The instruction then reads, writes or bit-modifies registers, with the address pointer advancing after every data byte. Shortcut instructions load the pointer with the start of a transmit or receive buffer, taken from the low bits of the opcode. A request-to-send instruction emits a strobe for any subset of the three transmit buffers.

The SPI pins are oversampled by the system clock through two-flop synchronizers, so each sclk half period must last at least 6 clock cycles. The protocol engine reads the register file through a separate combinational port. It also receives two outputs: a transmit-request strobe, and per-buffer pulses that clear a receive buffer's interrupt flag once that buffer has been read through its shortcut.

Top module: `spi_can_cmd`

## Requirements
- R1: After rst_n is released, register 0x0F (control, mode field in bits 7:5) holds 0x80 (mode 3'b100 = configuration) and every other register holds 0x00. miso, rts_pulse and rxf_clr are 0.
- R2: Write (opcode 0x02, address, data...) stores each data byte at consecutive addresses for as long as cs_n stays low.
- R3: Read (opcode 0x03, address, dummy bytes) shifts out the registers at consecutive addresses, MSB first. The first bit is valid before the first rising sclk edge of the byte after the address.
- R4: Bit modify (0x05, address, mask, data) updates only the bits where the mask is 1. Any further bytes in the frame are ignored.
- R5: Load transmit buffer (0x40 | k, k = 0..5) writes data starting at 0x31, 0x36, 0x41, 0x46, 0x51 or 0x56 for k = 0..5, with auto-increment. 0x46 and 0x47 are unrecognised.
- R6: Request-to-send (0x80 | n) drives rts_pulse[2:0] = n for exactly one clock cycle. Bit i requests transmit buffer i.
- R7: Read receive buffer (0x90 | m<<1, m = 0..3) shifts out data from 0x61, 0x66, 0x71 or 0x76 for m = 0..3. When cs_n rises, rxf_clr bit m[1] pulses high for exactly one clock cycle.
- R8: Reset instruction 0xC0 returns every register to its R1 value, so the mode field again reads configuration.
- R9: After an unrecognised opcode, all bytes up to the rise of cs_n have no effect and miso stays 0.
- R10: A rise of cs_n part-way through a byte discards that byte with no side effect. The next frame starts cleanly at an opcode.
- R11: The address pointer wraps from 0x7F to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in |
| miso | output | 1 | SPI data out, 0 when not reading |
| eng_addr | input | 7 | Protocol-engine read address |
| eng_rdata | output | 8 | Register contents at eng_addr |
| rts_pulse | output | 3 | One-cycle transmit-request strobe per buffer |
| rxf_clr | output | 2 | One-cycle receive-flag clear per receive buffer |

## Verification
The embedded properties check the following on every cycle:
- Strobe shape: the transmit request is one cycle wide, and the clear pulses are at most one-hot and appear only after chip select is released.
- miso stays quiet outside a read phase.
- The frame state returns to the opcode phase while chip select is high.
- The mode field is back in configuration right after a reset instruction.

Only the bench scenarios can show the data-path behaviour:
- stored and returned bytes, auto-increment and address wrap;
- mask merging, and the shortcut start addresses;
- that aborted partial bytes and unrecognised opcodes leave the register file untouched.

// File: rtl/spi_can_cmd.sv
module spi_can_cmd #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F,
  parameter logic [7:0] CTRL_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [ADDR_W-1:0] eng_addr,
  output logic [7:0]        eng_rdata,
  output logic [2:0]        rts_pulse,
  output logic [1:0]        rxf_clr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = 1;

  typedef enum logic [3:0] {
    P_OP, P_ARD, P_AWR, P_ABM, P_MASK, P_BMD, P_WR, P_RD, P_IDLE
  } phase_t;

  logic [7:0] mem [DEPTH];
  logic [2:0] cs_sy, sck_sy;
  logic [1:0] mosi_sy;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] obuf, mask;
  logic [ADDR_W-1:0] ptr;
  logic rd_act, rxb_pend, rxb_sel;
  phase_t ph;

  wire cs_s     = cs_sy[1];
  wire cs_rise  = cs_sy[1] & ~cs_sy[2];
  wire sck_rise = ~cs_s & sck_sy[1] & ~sck_sy[2];
  wire sck_fall = ~cs_s & ~sck_sy[1] & sck_sy[2];
  wire byte_done = sck_rise && (bitcnt == 3'd7);
  wire [7:0] bval = {sh, mosi_sy[1]};

  wire is_reset = bval == 8'hC0;
  wire is_read  = bval == 8'h03;
  wire is_write = bval == 8'h02;
  wire is_bm    = bval == 8'h05;
  wire is_ltx   = (bval[7:3] == 5'b01000) && (bval[2:0] <= 3'd5);
  wire is_rts   = bval[7:3] == 5'b10000;
  wire is_rrx   = (bval[7:3] == 5'b10010) && !bval[0];
  wire soft_rst = byte_done && (ph == P_OP) && is_reset;

  wire [7:0] tx_start = 8'h31 + {3'b000, bval[2:1], 3'b000} + {3'b000, bval[2:1], 3'b000}
                      + (bval[0] ? 8'd5 : 8'd0);
  wire [7:0] rx_start = 8'h61 + (bval[2] ? 8'h10 : 8'h00) + (bval[1] ? 8'd5 : 8'd0);
  wire [ADDR_W-1:0] tx_a = tx_start[ADDR_W-1:0];
  wire [ADDR_W-1:0] rx_a = rx_start[ADDR_W-1:0];
  wire [ADDR_W-1:0] b_a  = bval[ADDR_W-1:0];

  assign miso = rd_act & obuf[7];
  assign eng_rdata = mem[eng_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sy <= 3'b111;
      sck_sy <= 3'b000;
      mosi_sy <= 2'b00;
    end else begin
      cs_sy <= {cs_sy[1:0], cs_n};
      sck_sy <= {sck_sy[1:0], sclk};
      mosi_sy <= {mosi_sy[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == int'(CTRL_ADDR)) ? CTRL_RST : 8'h00;
      bitcnt <= '0; sh <= '0; obuf <= '0; mask <= '0; ptr <= '0;
      rd_act <= 1'b0; rxb_pend <= 1'b0; rxb_sel <= 1'b0; ph <= P_OP;
      rts_pulse <= '0; rxf_clr <= '0;
    end else begin
      rts_pulse <= '0;
      rxf_clr <= '0;
      if (cs_s) begin
        bitcnt <= '0;
        ph <= P_OP;
        rd_act <= 1'b0;
        rxb_pend <= 1'b0;
        if (cs_rise && rxb_pend) rxf_clr <= 2'b01 << rxb_sel;
      end else begin
        if (sck_fall && bitcnt != 3'd0) obuf <= {obuf[6:0], 1'b0};
        if (sck_rise) begin
          bitcnt <= bitcnt + 3'd1;
          sh <= bval[6:0];
        end
        if (byte_done) begin
          case (ph)
            P_OP: begin
              if (is_reset) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= (i == int'(CTRL_ADDR)) ? CTRL_RST : 8'h00;
                ph <= P_IDLE;
              end else if (is_read) ph <= P_ARD;
              else if (is_write) ph <= P_AWR;
              else if (is_bm) ph <= P_ABM;
              else if (is_ltx) begin
                ptr <= tx_a;
                ph <= P_WR;
              end else if (is_rts) begin
                rts_pulse <= bval[2:0];
                ph <= P_IDLE;
              end else if (is_rrx) begin
                obuf <= mem[rx_a];
                ptr <= rx_a + ONE;
                rd_act <= 1'b1;
                rxb_pend <= 1'b1;
                rxb_sel <= bval[2];
                ph <= P_RD;
              end else ph <= P_IDLE;
            end
            P_ARD: begin
              obuf <= mem[b_a];
              ptr <= b_a + ONE;
              rd_act <= 1'b1;
              ph <= P_RD;
            end
            P_AWR: begin ptr <= b_a; ph <= P_WR; end
            P_ABM: begin ptr <= b_a; ph <= P_MASK; end
            P_MASK: begin mask <= bval; ph <= P_BMD; end
            P_BMD: begin
              mem[ptr] <= (mem[ptr] & ~mask) | (bval & mask);
              ph <= P_IDLE;
            end
            P_WR: begin mem[ptr] <= bval; ptr <= ptr + ONE; end
            P_RD: begin obuf <= mem[ptr]; ptr <= ptr + ONE; end
            default: ;
          endcase
        end
      end
    end
  end

  a_r6_rts_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|rts_pulse) |=> (rts_pulse == 3'b000));
  a_r7_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rxf_clr));
  a_r7_clr_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|rxf_clr) |-> cs_sy[2]);
  a_r9_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_IDLE || ph == P_OP) |-> !miso);
  a_r8_mode_config: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mem[CTRL_ADDR][7:5] == CTRL_RST[7:5]));
  a_r10_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (ph == P_OP && bitcnt == 3'd0));
endmodule

// File: tb/tb_spi_can_cmd.sv
module tb_spi_can_cmd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [6:0] eng_addr = '0;
  logic [7:0] eng_rdata;
  logic [2:0] rts_pulse;
  logic [1:0] rxf_clr;
  int checks = 0, failures = 0;
  logic [2:0] rts_seen = '0;
  int rts_cyc = 0;
  logic [1:0] clr_seen = '0;
  int clr_cyc = 0;

  always #5 clk = ~clk;

  spi_can_cmd dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .eng_addr(eng_addr), .eng_rdata(eng_rdata),
    .rts_pulse(rts_pulse), .rxf_clr(rxf_clr));

  always @(posedge clk) begin
    if (|rts_pulse) begin rts_seen <= rts_seen | rts_pulse; rts_cyc <= rts_cyc + 1; end
    if (|rxf_clr) begin clr_seen <= clr_seen | rxf_clr; clr_cyc <= clr_cyc + 1; end
  end

  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h2A3C, 16'h7FFF, 16'h1001, 16'h5580, 16'h0F5A};

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hw; repeat (10) @(negedge clk); endtask
  task automatic sbeg; @(negedge clk) cs_n = 1'b0; hw(); endtask
  task automatic send; hw(); cs_n = 1'b1; repeat (20) @(negedge clk); endtask

  task automatic sbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      hw();
      rx[i] = miso;
      sclk = 1'b1;
      hw();
      sclk = 1'b0;
    end
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    sbits(tx, 8, rx);
  endtask

  task automatic rdreg(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk) eng_addr = a;
    @(negedge clk) v = eng_rdata;
  endtask

  task automatic spi_wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    sbeg(); sbyte(8'h02, r); sbyte(a, r); sbyte(d, r); send();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, r;
    logic [7:0] st;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rdreg(7'h0F, v); chk(v == 8'h80, "R1 ctrl reset", v, 8'h80);
    rdreg(7'h00, v); chk(v == 8'h00, "R1 reg0 reset", v, 8'h00);
    rdreg(7'h31, v); chk(v == 8'h00, "R1 reg31 reset", v, 8'h00);
    chk(miso == 1'b0 && rts_pulse == 3'b0 && rxf_clr == 2'b0, "R1 outputs idle",
        {4'h0, miso, rts_pulse[0], rxf_clr}, 8'h00);

    // table: single write then read back (R2, R3)
    for (int k = 0; k < 6; k++) begin
      spi_wr(VEC[k][15:8], VEC[k][7:0]);
      rdreg(VEC[k][14:8], v);
      chk(v == VEC[k][7:0], "R2 single write", v, VEC[k][7:0]);
      sbeg(); sbyte(8'h03, r); sbyte(VEC[k][15:8], r); sbyte(8'h00, v); send();
      chk(v == VEC[k][7:0], "R3 single read", v, VEC[k][7:0]);
    end

    // R2 burst write, R3 burst read
    sbeg(); sbyte(8'h02, r); sbyte(8'h20, r);
    for (int k = 0; k < 4; k++) sbyte(8'h11 * (k + 1), r);
    send();
    for (int k = 0; k < 4; k++) begin
      rdreg(7'h20 + 7'(k), v);
      chk(v == 8'(8'h11 * (k + 1)), "R2 burst write", v, 8'(8'h11 * (k + 1)));
    end
    sbeg(); sbyte(8'h03, r); sbyte(8'h20, r);
    for (int k = 0; k < 4; k++) begin
      sbyte(8'h00, v);
      chk(v == 8'(8'h11 * (k + 1)), "R3 burst read", v, 8'(8'h11 * (k + 1)));
    end
    send();

    // R11 wrap
    sbeg(); sbyte(8'h02, r); sbyte(8'h7F, r); sbyte(8'hDE, r); sbyte(8'hAD, r); send();
    rdreg(7'h7F, v); chk(v == 8'hDE, "R11 last addr", v, 8'hDE);
    rdreg(7'h00, v); chk(v == 8'hAD, "R11 wrapped", v, 8'hAD);

    // R4 bit modify with trailing byte
    spi_wr(8'h30, 8'hF0);
    sbeg(); sbyte(8'h05, r); sbyte(8'h30, r); sbyte(8'h3C, r); sbyte(8'hAA, r); sbyte(8'h55, r); send();
    rdreg(7'h30, v); chk(v == 8'hE8, "R4 masked merge", v, 8'hE8);
    rdreg(7'h31, v); chk(v == 8'h00, "R4 trailing byte ignored", v, 8'h00);

    // R5 load transmit buffer shortcuts
    for (int k = 0; k < 6; k++) begin
      st = 8'h31 + 8'(16 * (k / 2)) + 8'(5 * (k % 2));
      sbeg(); sbyte(8'h40 | 8'(k), r); sbyte(8'hB0 + 8'(k), r); sbyte(8'hC0 + 8'(k), r); send();
      rdreg(st[6:0], v); chk(v == 8'hB0 + 8'(k), "R5 ltx first", v, 8'hB0 + 8'(k));
      rdreg(st[6:0] + 7'd1, v); chk(v == 8'hC0 + 8'(k), "R5 ltx next", v, 8'hC0 + 8'(k));
    end
    sbeg(); sbyte(8'h46, r); sbyte(8'h77, r); send();
    rdreg(7'h31, v); chk(v == 8'hB0, "R5 ltx 0x46 ignored", v, 8'hB0);
    rdreg(7'h00, v); chk(v == 8'hAD, "R5 ltx 0x46 no write", v, 8'hAD);

    // R6 request-to-send
    rts_seen = '0; rts_cyc = 0;
    sbeg(); sbyte(8'h85, r); send();
    chk(rts_seen == 3'b101, "R6 rts bits", {5'b0, rts_seen}, 8'h05);
    chk(rts_cyc == 1, "R6 rts width", 8'(rts_cyc), 8'h01);
    rts_seen = '0; rts_cyc = 0;
    sbeg(); sbyte(8'h87, r); send();
    chk(rts_seen == 3'b111, "R6 rts all", {5'b0, rts_seen}, 8'h07);

    // R7 read receive buffer shortcuts
    spi_wr(8'h61, 8'h61); spi_wr(8'h66, 8'h66); spi_wr(8'h71, 8'h71); spi_wr(8'h76, 8'h76);
    for (int m = 0; m < 4; m++) begin
      st = 8'h61 + 8'(16 * (m / 2)) + 8'(5 * (m % 2));
      clr_seen = '0; clr_cyc = 0;
      sbeg(); sbyte(8'h90 | 8'(m << 1), r); sbyte(8'h00, v); send();
      chk(v == st, "R7 rrx data", v, st);
      chk(clr_seen == ((m < 2) ? 2'b01 : 2'b10) && clr_cyc == 1, "R7 flag clear",
          {clr_seen, 6'(clr_cyc)}, {((m < 2) ? 2'b01 : 2'b10), 6'd1});
    end

    // R9 unrecognised opcode
    sbeg(); sbyte(8'h11, r); sbyte(8'h00, v); sbyte(8'h99, r); send();
    chk(v == 8'h00 && r == 8'h00, "R9 miso quiet", v | r, 8'h00);
    rdreg(7'h00, v); chk(v == 8'hAD, "R9 no write", v, 8'hAD);

    // R10 abort mid-byte
    sbeg(); sbyte(8'h02, r); sbyte(8'h40, r); sbits(8'hFF, 4, r); send();
    rdreg(7'h40, v); chk(v == 8'h00, "R10 partial data dropped", v, 8'h00);
    sbeg(); sbits(8'hC0, 4, r); send();
    rdreg(7'h0F, v); chk(v == 8'h5A, "R10 partial reset dropped", v, 8'h5A);
    spi_wr(8'h40, 8'h12);
    rdreg(7'h40, v); chk(v == 8'h12, "R10 clean restart", v, 8'h12);

    // R8 reset instruction
    sbeg(); sbyte(8'hC0, r); send();
    rdreg(7'h0F, v); chk(v == 8'h80, "R8 ctrl config mode", v, 8'h80);
    rdreg(7'h20, v); chk(v == 8'h00, "R8 reg cleared", v, 8'h00);
    rdreg(7'h40, v); chk(v == 8'h00, "R8 reg40 cleared", v, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule